// File: doc/BRIEF.md
# Synchronous SRAM Burst Address Generator

This block turns one presented address into a run of up to four array accesses for a single-data-rate synchronous SRAM port. A load strobe latches an address and starts a burst. Each later clock on which the active-low advance input is sampled low steps a 2-bit beat counter. The low two bits of the access address then follow either a linear or an interleaved order around the starting location, and the upper bits stay put. After the fourth beat the sequence comes back to the starting address, unless a new address arrived during the burst. In that case the new address is parked in a one-entry pending slot, and the next burst starts from it once the current four beats are finished.

When advance is inactive, the block does not step. It either starts an access at a freshly strobed address at once, starts the parked address, or repeats the current address. The ordering mode is latched with each start address, so a change on the mode pin only matters at the next load. A pending flag and the beat index are brought out next to the access address so that a controller or a bench can follow the sequence.

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous active-high reset clears the valid, pending and beat outputs and the access address to zero. The block then waits idle for a load.
- R2: When idle, a load sampled high starts a burst. From the next cycle, `acc_valid_o` is 1, `acc_addr_o` equals the presented address and `beat_o` is 0.
- R3: With mode 0 (linear), each advance (advance input low, no pending restart) increments `beat_o` modulo 4. The access address low two bits become (start low bits + beat) mod 4, and the upper bits do not change.
- R4: With mode 1 (interleaved), the access address low two bits are start low bits XOR beat. A start of 2 gives 2, 3, 0, 1.
- R5: An advance after beat 3 with nothing pending returns to beat 0 and to the originally loaded address.
- R6: A load that arrives together with an advance during a burst sets `pend_o` and does not disturb the running sequence.
- R7: An advance on beat 3 while an address is pending starts a new burst from the pending address at beat 0 and clears `pend_o`.
- R8: With advance inactive, no load and nothing pending, the access address and beat index hold their values.
- R9: With advance inactive, a load starts a burst at the presented address on the next cycle (beat 0) and drops any pending address.
- R10: The mode input is sampled only when a burst starts. A change during a burst leaves the running order unchanged.
- R11: While idle, the advance input without a load has no effect, and `acc_valid_o` stays 0.
- R12: With advance inactive, no load and an address pending, the next cycle starts a burst from the pending address at beat 0 and clears `pend_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_i | input | 1 | Address strobe / load request |
| adv_n_i | input | 1 | Advance request, active low |
| mode_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_i | input | ADDR_W | Presented external address |
| acc_valid_o | output | 1 | An access address is being driven |
| acc_addr_o | output | ADDR_W | Internal array address for this cycle's access |
| beat_o | output | 2 | Beat index within the current burst |
| pend_o | output | 1 | A queued address is waiting for the next burst |

## Verification
Linear and interleaved bursts use start addresses whose low bits are nonzero, so an order error or a wrong carry into the upper bits shows up in the address. Full wraps tell a return-to-start apart from a drift past the fourth beat. Loads are placed in the middle of a burst and then followed by a further advance, by an idle advance, or by a direct load. These three cases separate the queued restart, the early restart from the parked address, and the discard of the parked address. Holding with advance inactive, and toggling the mode pin mid-burst, confirm that no stimulus alters the sequence when it should not.

// File: rtl/bag_pkg.sv
package bag_pkg;

    localparam int BEAT_W = 2;
    localparam int BEATS  = 1 << BEAT_W;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        ORD_LINEAR      = 1'b0,
        ORD_INTERLEAVED = 1'b1
    } order_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } state_e;

    typedef enum logic [2:0] {
        ACT_NONE      = 3'd0,
        ACT_LOAD_EXT  = 3'd1,
        ACT_LOAD_PEND = 3'd2,
        ACT_STEP      = 3'd3,
        ACT_HOLD      = 3'd4
    } act_e;

    typedef struct packed {
        act_e act;
        logic capture;
        logic drop;
    } ctl_t;

    function automatic beat_t order_low(beat_t start, beat_t idx, order_e ord);
        beat_t r;
        if (ord == ORD_INTERLEAVED) begin
            r = start ^ idx;
        end else begin
            r = beat_t'(start + idx);
        end
        return r;
    endfunction

    function automatic logic is_start(act_e a);
        return (a == ACT_LOAD_EXT) || (a == ACT_LOAD_PEND);
    endfunction

endpackage

// File: rtl/bag_beat_ctr.sv
module bag_beat_ctr
    import bag_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr_i,
    input  logic  step_i,
    output beat_t beat_o,
    output logic  last_o
);

    beat_t beat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
        end else if (clr_i) begin
            beat_q <= '0;
        end else if (step_i) begin
            beat_q <= beat_t'(beat_q + beat_t'(1));
        end
    end

    assign beat_o = beat_q;
    assign last_o = (beat_q == beat_t'(BEATS - 1));

    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (rst)
        (step_i && !clr_i) |=> (beat_q == beat_t'($past(beat_q) + beat_t'(1)))); // R3

    AST_BEAT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (beat_q == '0)); // R2

endmodule

// File: rtl/bag_pend_slot.sv
module bag_pend_slot #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_i,
    input  logic [ADDR_W-1:0] cap_addr_i,
    input  logic              take_i,
    input  logic              drop_i,
    output logic              pend_o,
    output logic [ADDR_W-1:0] addr_o
);

    logic              pend_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            addr_q <= '0;
        end else begin
            if (cap_i) begin
                pend_q <= 1'b1;
                addr_q <= cap_addr_i;
            end else if (take_i || drop_i) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign pend_o = pend_q;
    assign addr_o = addr_q;

    AST_PEND_KEEP: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !take_i && !drop_i && !cap_i) |=> (pend_q && $stable(addr_q))); // R6

    AST_PEND_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (take_i && !cap_i) |=> !pend_q); // R7

endmodule

// File: rtl/bag_seq_map.sv
module bag_seq_map
    import bag_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] start_i,
    input  beat_t             beat_i,
    input  order_e            ord_i,
    output logic [ADDR_W-1:0] addr_o
);

    beat_t low;

    always_comb begin
        low = order_low(start_i[BEAT_W-1:0], beat_i, ord_i);
    end

    generate
        if (ADDR_W > BEAT_W) begin : g_upper
            assign addr_o = {start_i[ADDR_W-1:BEAT_W], low};
        end else begin : g_low_only
            assign addr_o = low[ADDR_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import bag_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_i,
    input  logic              adv_n_i,
    input  logic              mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              acc_valid_o,
    output logic [ADDR_W-1:0] acc_addr_o,
    output logic [1:0]        beat_o,
    output logic              pend_o
);

    state_e            state_q;
    logic [ADDR_W-1:0] start_q;
    order_e            ord_q;
    ctl_t              ctl;
    beat_t             beat;
    logic              last;
    logic              pend;
    logic [ADDR_W-1:0] pend_addr;
    logic [ADDR_W-1:0] map_addr;
    logic [ADDR_W-1:0] next_start;

    // Decide this cycle's action from state, strobe, advance and pending slot.
    always_comb begin
        ctl.act     = ACT_NONE;
        ctl.capture = 1'b0;
        ctl.drop    = 1'b0;
        if (state_q == ST_IDLE) begin
            if (ld_i) begin
                ctl.act = ACT_LOAD_EXT;
            end
        end else if (!adv_n_i) begin
            ctl.capture = ld_i;
            if (last && pend) begin
                ctl.act = ACT_LOAD_PEND;
            end else begin
                ctl.act = ACT_STEP;
            end
        end else begin
            if (ld_i) begin
                ctl.act  = ACT_LOAD_EXT;
                ctl.drop = 1'b1;
            end else if (pend) begin
                ctl.act = ACT_LOAD_PEND;
            end else begin
                ctl.act = ACT_HOLD;
            end
        end
    end

    always_comb begin
        next_start = (ctl.act == ACT_LOAD_PEND) ? pend_addr : addr_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            start_q <= '0;
            ord_q   <= ORD_LINEAR;
        end else if (is_start(ctl.act)) begin
            state_q <= ST_BURST;
            start_q <= next_start;
            ord_q   <= order_e'(mode_i);
        end
    end

    bag_beat_ctr u_ctr (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (is_start(ctl.act)),
        .step_i (ctl.act == ACT_STEP),
        .beat_o (beat),
        .last_o (last)
    );

    bag_pend_slot #(.ADDR_W(ADDR_W)) u_pend (
        .clk        (clk),
        .rst        (rst),
        .cap_i      (ctl.capture),
        .cap_addr_i (addr_i),
        .take_i     (ctl.act == ACT_LOAD_PEND),
        .drop_i     (ctl.drop),
        .pend_o     (pend),
        .addr_o     (pend_addr)
    );

    bag_seq_map #(.ADDR_W(ADDR_W)) u_map (
        .start_i (start_q),
        .beat_i  (beat),
        .ord_i   (ord_q),
        .addr_o  (map_addr)
    );

    assign acc_valid_o = (state_q == ST_BURST);
    assign acc_addr_o  = map_addr;
    assign beat_o      = beat;
    assign pend_o      = pend;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!acc_valid_o && !pend_o && beat_o == 2'd0)); // R1

    AST_LOAD_START: assert property (@(posedge clk) disable iff (rst)
        (!acc_valid_o && ld_i) |=> (acc_valid_o && acc_addr_o == $past(addr_i) && beat_o == 2'd0)); // R2

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
        (acc_valid_o && !adv_n_i && !pend_o) |=> $stable(acc_addr_o[ADDR_W-1:BEAT_W])); // R3

    AST_HOLD_STILL: assert property (@(posedge clk) disable iff (rst)
        (acc_valid_o && adv_n_i && !ld_i && !pend_o) |=> ($stable(acc_addr_o) && $stable(beat_o))); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!acc_valid_o && !ld_i) |=> !acc_valid_o); // R11

    AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (rst)
        (acc_valid_o && adv_n_i && ld_i) |=> (acc_addr_o == $past(addr_i) && !pend_o)); // R9

endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb_top;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ld_i = 1'b0;
    logic          adv_n_i = 1'b1;
    logic          mode_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic          acc_valid_o;
    logic [AW-1:0] acc_addr_o;
    logic [1:0]    beat_o;
    logic          pend_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .ld_i        (ld_i),
        .adv_n_i     (adv_n_i),
        .mode_i      (mode_i),
        .addr_i      (addr_i),
        .acc_valid_o (acc_valid_o),
        .acc_addr_o  (acc_addr_o),
        .beat_o      (beat_o),
        .pend_o      (pend_o)
    );

    // Drive one cycle of inputs at the falling edge, then sample after the rising edge.
    task automatic cyc(input logic ld, input logic advn, input logic md, input logic [AW-1:0] a,
                       input logic ev, input logic [AW-1:0] ea, input logic [1:0] eb,
                       input logic ep, input string req);
        @(negedge clk);
        ld_i = ld; adv_n_i = advn; mode_i = md; addr_i = a;
        @(posedge clk);
        #2;
        checks++;
        if (acc_valid_o !== ev || (ev && acc_addr_o !== ea) || beat_o !== eb || pend_o !== ep) begin
            errors++;
            $display("FAIL %s: got v=%0b a=%h b=%0d p=%0b expected v=%0b a=%h b=%0d p=%0b",
                     req, acc_valid_o, acc_addr_o, beat_o, pend_o, ev, ea, eb, ep);
        end
    endtask

    task automatic t_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        @(negedge clk); rst = 1'b0;
        checks++;
        if (acc_valid_o !== 1'b0 || pend_o !== 1'b0 || beat_o !== 2'd0 || acc_addr_o !== '0) begin
            errors++;
            $display("FAIL R1: got v=%0b a=%h b=%0d p=%0b expected v=0 a=0000 b=0 p=0",
                     acc_valid_o, acc_addr_o, beat_o, pend_o);
        end
        cyc(0, 0, 0, 16'h1111, 0, 16'h0000, 2'd0, 0, "R11");
        cyc(0, 0, 1, 16'h2222, 0, 16'h0000, 2'd0, 0, "R11");
    endtask

    task automatic t_linear();
        cyc(1, 1, 0, 16'h1231, 1, 16'h1231, 2'd0, 0, "R2");
        cyc(0, 0, 0, 16'h0000, 1, 16'h1232, 2'd1, 0, "R3");
        cyc(0, 0, 0, 16'h0000, 1, 16'h1233, 2'd2, 0, "R3");
        cyc(0, 0, 0, 16'h0000, 1, 16'h1230, 2'd3, 0, "R3");
        cyc(0, 0, 0, 16'h0000, 1, 16'h1231, 2'd0, 0, "R5");
    endtask

    task automatic t_interleaved();
        cyc(1, 1, 1, 16'h00A6, 1, 16'h00A6, 2'd0, 0, "R2");
        cyc(0, 0, 1, 16'h0000, 1, 16'h00A7, 2'd1, 0, "R4");
        cyc(0, 0, 1, 16'h0000, 1, 16'h00A4, 2'd2, 0, "R4");
        cyc(0, 0, 1, 16'h0000, 1, 16'h00A5, 2'd3, 0, "R4");
        cyc(0, 0, 1, 16'h0000, 1, 16'h00A6, 2'd0, 0, "R5");
    endtask

    task automatic t_hold();
        cyc(0, 1, 1, 16'h3333, 1, 16'h00A6, 2'd0, 0, "R8");
        cyc(0, 0, 1, 16'h0000, 1, 16'h00A7, 2'd1, 0, "R4");
        cyc(0, 1, 0, 16'h4444, 1, 16'h00A7, 2'd1, 0, "R8");
        cyc(0, 1, 0, 16'h4444, 1, 16'h00A7, 2'd1, 0, "R8");
    endtask

    task automatic t_mode_static();
        cyc(1, 1, 0, 16'h0045, 1, 16'h0045, 2'd0, 0, "R2");
        cyc(0, 0, 1, 16'h0000, 1, 16'h0046, 2'd1, 0, "R10");
        cyc(0, 0, 1, 16'h0000, 1, 16'h0047, 2'd2, 0, "R10");
        cyc(0, 0, 1, 16'h0000, 1, 16'h0044, 2'd3, 0, "R10");
    endtask

    task automatic t_queued();
        cyc(1, 1, 0, 16'h0100, 1, 16'h0100, 2'd0, 0, "R2");
        cyc(1, 0, 0, 16'h0203, 1, 16'h0101, 2'd1, 1, "R6");
        cyc(0, 0, 0, 16'h0000, 1, 16'h0102, 2'd2, 1, "R6");
        cyc(0, 0, 0, 16'h0000, 1, 16'h0103, 2'd3, 1, "R6");
        cyc(0, 0, 0, 16'h0000, 1, 16'h0203, 2'd0, 0, "R7");
        cyc(0, 0, 0, 16'h0000, 1, 16'h0200, 2'd1, 0, "R7");
    endtask

    task automatic t_idle_restart();
        cyc(1, 1, 0, 16'h0300, 1, 16'h0300, 2'd0, 0, "R2");
        cyc(1, 0, 0, 16'h0402, 1, 16'h0301, 2'd1, 1, "R6");
        cyc(0, 1, 0, 16'h0000, 1, 16'h0402, 2'd0, 0, "R12");
        cyc(0, 0, 0, 16'h0000, 1, 16'h0403, 2'd1, 0, "R12");
    endtask

    task automatic t_direct_load();
        cyc(1, 1, 1, 16'h0500, 1, 16'h0500, 2'd0, 0, "R2");
        cyc(1, 0, 1, 16'h0601, 1, 16'h0501, 2'd1, 1, "R6");
        cyc(1, 1, 1, 16'h0702, 1, 16'h0702, 2'd0, 0, "R9");
        cyc(0, 0, 1, 16'h0000, 1, 16'h0703, 2'd1, 0, "R9");
        cyc(0, 0, 1, 16'h0000, 1, 16'h0700, 2'd2, 0, "R9");
    endtask

    initial begin
        t_reset();
        t_linear();
        t_interleaved();
        t_hold();
        t_mode_static();
        t_queued();
        t_idle_restart();
        t_direct_load();
        t_reset();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule